// File: doc/BRIEF.md
# Lookup-Table Brightness Ramp Sequencer

This block plays brightness patterns for a small group of PWM channels. It holds a shared table of 9-bit brightness values. Each channel walks a window of that table, from a low index to a high index. Every position is held for a programmable number of millisecond ticks. Each channel puts out the current table index and the duty value found at that index, and a separate PWM generator turns the duty into a waveform.

Each channel has its own window bounds and step time. Each end of the window can add its own dwell. A channel can run in either direction, wrap around or bounce, and either loop for ever or play once and stop. When its window has equal bounds, a channel does not ramp and instead puts out a fixed duty of its own. A single write to the start register launches every channel whose bit is set, all on the same clock edge.

Top module: `lut_ramp_seq`

## Requirements
- R1: The table holds 64 entries of 9 bits each, written at addresses 0x00 to 0x3F from wr_data[8:0]. A table write is ignored while any channel is busy.
- R2: Channel c owns addresses 0x40+8*c+f. The field codes f are: 0 low index, 1 high index, 2 step ticks (16 bits), 3 high-end dwell count, 4 low-end dwell count, 5 mode flags, 6 fixed duty. The mode flag bits are: bit0 reverse, bit1 loop, bit2 bounce, bit3 high dwell enable, bit4 low dwell enable. A write to a channel's fields is ignored while that channel is busy.
- R3: A write to address 0x80 starts every channel whose bit in wr_data is set, all on that same clock edge. A started channel goes busy with its index at the low index, or at the high index when reverse is set, and its done flag is cleared.
- R4: If the low and high indices are equal when a channel is started, it stays idle and its duty output is its fixed duty value.
- R5: While busy, the index moves only on the tick that completes a step of N ticks. A step value of 0 acts as 1.
- R6: Without bounce, the index moves toward the far end. In loop mode, once the far end has been held, the index jumps back to the starting end.
- R7: With bounce, reaching an end reverses the direction, and the next index is the neighbour of that end, so the end entry is not repeated. A one-shot bounce run finishes when it returns to its starting end.
- R8: When a dwell is enabled, the channel holds the high-index entry (or the low-index entry) for that end's dwell count of extra steps before moving on. A count of 0 adds nothing.
- R9: In one-shot mode the channel stops after holding the final entry. It then raises done and keeps putting out that entry's duty, even if the table is rewritten later, until it is started or stopped again.
- R10: A write to address 0x81 stops every channel whose bit is set. Busy and done are cleared, and the duty output returns to the fixed duty.
- R11: lut_addr carries each channel's current index. While the channel is busy, duty carries the table value at that index.
- R12: After reset all channels are idle and not done, with index 0, and every duty output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| lut_addr | output | NUM_CH*6 | Current table index per channel |
| duty | output | NUM_CH*9 | Duty value per channel |
| busy | output | NUM_CH | Channel is ramping |
| done | output | NUM_CH | One-shot run finished |

## Verification
The bench targets the turning points of the index walk.

- **Wrap and bounce at the ends.** A design that repeated the end entry on a bounce, or wrapped without holding the far end, would show an index one step off at a known tick count.
- **Dwell counts.** Both end dwells are checked, including a count of zero. A design with an off-by-one dwell counter, or one that applied the dwell to the wrong end, would shift every later index.
- **One-shot bounce end.** A one-shot bounce run must stop at the start end and not at the far end.
- **Hold and ignore rules.** The bench checks that a finished channel keeps its duty when the table is rewritten afterwards. It also checks that configuration and table writes made during a run leave the walk unchanged, because such writes are ignored.

// File: rtl/lut_ramp_seq_pkg.sv
package lut_ramp_seq_pkg;
    localparam int LUT_DEPTH = 64;
    localparam int IDX_W     = $clog2(LUT_DEPTH);
    localparam int DUTY_W    = 9;
    localparam int STEP_W    = 16;
    localparam int PAUSE_W   = 8;
    localparam int FLAG_W    = 5;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;

    // mode flag bit positions
    localparam int F_REV  = 0;
    localparam int F_LOOP = 1;
    localparam int F_BNC  = 2;
    localparam int F_HIP  = 3;
    localparam int F_LOP  = 4;

    // address map
    localparam logic [ADDR_W-1:0] CH_BASE   = 8'h40;
    localparam logic [ADDR_W-1:0] CTL_BASE  = 8'h80;
    localparam logic [ADDR_W-1:0] START_REG = 8'h80;
    localparam logic [ADDR_W-1:0] STOP_REG  = 8'h81;

    localparam logic [2:0] FLD_LO    = 3'd0;
    localparam logic [2:0] FLD_HI    = 3'd1;
    localparam logic [2:0] FLD_STEP  = 3'd2;
    localparam logic [2:0] FLD_HIP   = 3'd3;
    localparam logic [2:0] FLD_LOP   = 3'd4;
    localparam logic [2:0] FLD_FLAGS = 3'd5;
    localparam logic [2:0] FLD_FIXED = 3'd6;

    typedef struct packed {
        logic [IDX_W-1:0]   lo;
        logic [IDX_W-1:0]   hi;
        logic [STEP_W-1:0]  step;
        logic [PAUSE_W-1:0] hi_pause;
        logic [PAUSE_W-1:0] lo_pause;
        logic [FLAG_W-1:0]  flags;
        logic [DUTY_W-1:0]  fixed_duty;
    } ch_cfg_t;

    typedef struct packed {
        logic               run;
        logic               done;
        logic               up;
        logic               turned;
        logic [IDX_W-1:0]   idx;
        logic [STEP_W-1:0]  tcnt;
        logic [PAUSE_W-1:0] pcnt;
        logic [DUTY_W-1:0]  held;
    } chan_st_t;
endpackage

// File: rtl/lut_ramp_regfile.sv
module lut_ramp_regfile
    import lut_ramp_seq_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic [NUM_CH-1:0]                      busy,
    output ch_cfg_t [NUM_CH-1:0]                   cfg_o,
    output logic [LUT_DEPTH-1:0][DUTY_W-1:0]       lut_o,
    output logic [NUM_CH-1:0]                      start_o,
    output logic [NUM_CH-1:0]                      stop_o
);
    localparam int SEL_W = 3;

    typedef struct packed {
        ch_cfg_t [NUM_CH-1:0]              cfg;
        logic [LUT_DEPTH-1:0][DUTY_W-1:0]  lut;
    } rf_st_t;

    rf_st_t            st_d, st_q;
    logic [SEL_W-1:0]  ch_sel;
    logic [2:0]        fld;
    logic              in_lut, in_ch;

    assign ch_sel = wr_addr[5:3];
    assign fld    = wr_addr[2:0];
    assign in_lut = wr_addr < CH_BASE;
    assign in_ch  = (wr_addr >= CH_BASE) && (wr_addr < CTL_BASE);

    always_comb begin
        st_d    = st_q;
        start_o = '0;
        stop_o  = '0;
        if (wr_en) begin
            if (in_lut) begin
                if (!(|busy)) st_d.lut[wr_addr[IDX_W-1:0]] = wr_data[DUTY_W-1:0];
            end else if (in_ch) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_sel == SEL_W'(c) && !busy[c]) begin
                        case (fld)
                            FLD_LO:    st_d.cfg[c].lo         = wr_data[IDX_W-1:0];
                            FLD_HI:    st_d.cfg[c].hi         = wr_data[IDX_W-1:0];
                            FLD_STEP:  st_d.cfg[c].step       = wr_data;
                            FLD_HIP:   st_d.cfg[c].hi_pause   = wr_data[PAUSE_W-1:0];
                            FLD_LOP:   st_d.cfg[c].lo_pause   = wr_data[PAUSE_W-1:0];
                            FLD_FLAGS: st_d.cfg[c].flags      = wr_data[FLAG_W-1:0];
                            FLD_FIXED: st_d.cfg[c].fixed_duty = wr_data[DUTY_W-1:0];
                            default: ;
                        endcase
                    end
                end
            end else if (wr_addr == START_REG) begin
                start_o = wr_data[NUM_CH-1:0];
            end else if (wr_addr == STOP_REG) begin
                stop_o = wr_data[NUM_CH-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign lut_o = st_q.lut;
endmodule

// File: rtl/lut_ramp_chan.sv
module lut_ramp_chan
    import lut_ramp_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  ch_cfg_t            cfg,
    input  logic               start,
    input  logic               stop,
    input  logic [DUTY_W-1:0]  lut_data,
    output logic [IDX_W-1:0]   idx_o,
    output logic [DUTY_W-1:0]  duty_o,
    output logic               run_o,
    output logic               done_o
);
    chan_st_t st_d, st_q;
    logic on_hi, on_lo, at_end, step_last, dwell_due;

    always_comb begin
        st_d      = st_q;
        on_hi     = st_q.idx == cfg.hi;
        on_lo     = st_q.idx == cfg.lo;
        at_end    = st_q.up ? on_hi : on_lo;
        step_last = (cfg.step <= STEP_W'(1)) || (st_q.tcnt == cfg.step - STEP_W'(1));
        dwell_due = (on_hi && cfg.flags[F_HIP] && (st_q.pcnt < cfg.hi_pause)) ||
                    (on_lo && cfg.flags[F_LOP] && (st_q.pcnt < cfg.lo_pause));

        if (st_q.run) st_d.held = lut_data;

        if (st_q.run && tick) begin
            if (!step_last) begin
                st_d.tcnt = st_q.tcnt + STEP_W'(1);
            end else begin
                st_d.tcnt = '0;
                if (dwell_due) begin
                    st_d.pcnt = st_q.pcnt + PAUSE_W'(1);
                end else begin
                    st_d.pcnt = '0;
                    if (!at_end) begin
                        st_d.idx = st_q.up ? st_q.idx + IDX_W'(1) : st_q.idx - IDX_W'(1);
                    end else if (cfg.flags[F_BNC]) begin
                        if (!cfg.flags[F_LOOP] && st_q.turned) begin
                            st_d.run  = 1'b0;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.up     = !st_q.up;
                            st_d.turned = 1'b1;
                            st_d.idx    = st_q.up ? st_q.idx - IDX_W'(1) : st_q.idx + IDX_W'(1);
                        end
                    end else if (!cfg.flags[F_LOOP]) begin
                        st_d.run  = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.idx = st_q.up ? cfg.lo : cfg.hi;
                    end
                end
            end
        end

        if (stop) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b0;
        end

        if (start) begin
            st_d.run    = cfg.lo != cfg.hi;
            st_d.done   = 1'b0;
            st_d.up     = !cfg.flags[F_REV];
            st_d.turned = 1'b0;
            st_d.idx    = cfg.flags[F_REV] ? cfg.hi : cfg.lo;
            st_d.tcnt   = '0;
            st_d.pcnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o  = st_q.idx;
    assign run_o  = st_q.run;
    assign done_o = st_q.done;
    assign duty_o = st_q.run  ? lut_data :
                    st_q.done ? st_q.held : cfg.fixed_duty;
endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
    import lut_ramp_seq_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_ms,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_CH*IDX_W-1:0]    lut_addr,
    output logic [NUM_CH*DUTY_W-1:0]   duty,
    output logic [NUM_CH-1:0]          busy,
    output logic [NUM_CH-1:0]          done
);
    ch_cfg_t [NUM_CH-1:0]              cfg;
    logic [LUT_DEPTH-1:0][DUTY_W-1:0]  lut;
    logic [NUM_CH-1:0]                 start, stop;

    lut_ramp_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .cfg_o   (cfg),
        .lut_o   (lut),
        .start_o (start),
        .stop_o  (stop)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [IDX_W-1:0] idx;
        lut_ramp_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_ms),
            .cfg      (cfg[c]),
            .start    (start[c]),
            .stop     (stop[c]),
            .lut_data (lut[idx]),
            .idx_o    (idx),
            .duty_o   (duty[c*DUTY_W +: DUTY_W]),
            .run_o    (busy[c]),
            .done_o   (done[c])
        );
        assign lut_addr[c*IDX_W +: IDX_W] = idx;
    end
endmodule

// File: rtl/lut_ramp_seq_chk.sv
module lut_ramp_seq_chk
    import lut_ramp_seq_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_ms,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [NUM_CH-1:0]         wr_mask,
    input logic [NUM_CH*IDX_W-1:0]   lut_addr,
    input logic [NUM_CH*DUTY_W-1:0]  duty,
    input logic [NUM_CH-1:0]         busy,
    input logic [NUM_CH-1:0]         done
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(busy[c] && done[c]));

        p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            busy[c] && !tick_ms && !wr_en |=> $stable(lut_addr[c*IDX_W +: IDX_W]));

        p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            busy[c] && !tick_ms && !wr_en |=> busy[c]);

        p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            done[c] && !wr_en |=> done[c]);

        p_done_duty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            done[c] && !wr_en |=> $stable(duty[c*DUTY_W +: DUTY_W]));

        p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == STOP_REG && wr_mask[c] |=> !busy[c] && !done[c]);

        p_start_clear_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == START_REG && wr_mask[c] |=> !done[c]);
    end
endmodule

bind lut_ramp_seq lut_ramp_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ms  (tick_ms),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_mask  (wr_data[NUM_CH-1:0]),
    .lut_addr (lut_addr),
    .duty     (duty),
    .busy     (busy),
    .done     (done)
);

// File: tb/lut_ramp_seq_bench.sv
module lut_ramp_seq_bench;
    localparam int NCH   = 2;
    localparam int WD    = 100000;
    localparam int FIXED = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NCH*6-1:0] lut_addr;
    logic [NCH*9-1:0] duty;
    logic [NCH-1:0]   busy, done;

    int  tests = 0;
    int  fails = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    lut_ramp_seq #(.NUM_CH(NCH)) u_lut_ramp_seq (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .lut_addr(lut_addr),
        .duty(duty), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [4:0]  flags;
        logic [5:0]  lo;
        logic [5:0]  hi;
        logic [7:0]  hp;
        logic [7:0]  lp;
        logic [15:0] step;
        logic [7:0]  ticks;
        logic [5:0]  exp_idx;
        logic        exp_run;
        logic        exp_done;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd0, 6'd2, 1'b1, 1'b0}, // R3 start at low
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd3, 6'd5, 1'b1, 1'b0}, // R6 forward
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd4, 6'd2, 1'b1, 1'b0}, // R6 wrap
        '{5'b00000, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd4, 6'd5, 1'b0, 1'b1}, // R9 one-shot end
        '{5'b00000, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd8, 6'd5, 1'b0, 1'b1}, // R9 stays done
        '{5'b00011, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd1, 6'd4, 1'b1, 1'b0}, // R6 reverse
        '{5'b00011, 6'd2, 6'd5, 8'd0, 8'd0, 16'd1, 8'd4, 6'd5, 1'b1, 1'b0}, // R6 reverse wrap
        '{5'b00110, 6'd2, 6'd4, 8'd0, 8'd0, 16'd1, 8'd3, 6'd3, 1'b1, 1'b0}, // R7 turn at high
        '{5'b00110, 6'd2, 6'd4, 8'd0, 8'd0, 16'd1, 8'd5, 6'd3, 1'b1, 1'b0}, // R7 turn at low
        '{5'b00100, 6'd2, 6'd4, 8'd0, 8'd0, 16'd1, 8'd4, 6'd2, 1'b1, 1'b0}, // R7 back at start
        '{5'b00100, 6'd2, 6'd4, 8'd0, 8'd0, 16'd1, 8'd5, 6'd2, 1'b0, 1'b1}, // R7 one-shot bounce end
        '{5'b01010, 6'd2, 6'd4, 8'd2, 8'd0, 16'd1, 8'd4, 6'd4, 1'b1, 1'b0}, // R8 high dwell
        '{5'b01010, 6'd2, 6'd4, 8'd2, 8'd0, 16'd1, 8'd5, 6'd2, 1'b1, 1'b0}, // R8 after dwell
        '{5'b10010, 6'd2, 6'd4, 8'd0, 8'd1, 16'd1, 8'd1, 6'd2, 1'b1, 1'b0}, // R8 low dwell
        '{5'b10010, 6'd2, 6'd4, 8'd0, 8'd1, 16'd1, 8'd2, 6'd3, 1'b1, 1'b0}, // R8 after low dwell
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd3, 8'd5, 6'd3, 1'b1, 1'b0}, // R5 step 3
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd3, 8'd6, 6'd4, 1'b1, 1'b0}, // R5 step 3
        '{5'b01010, 6'd2, 6'd4, 8'd0, 8'd0, 16'd1, 8'd3, 6'd2, 1'b1, 1'b0}, // R8 zero count
        '{5'b11110, 6'd2, 6'd3, 8'd1, 8'd1, 16'd1, 8'd5, 6'd2, 1'b1, 1'b0}, // R8 bounce dwell
        '{5'b11110, 6'd2, 6'd3, 8'd1, 8'd1, 16'd1, 8'd6, 6'd3, 1'b1, 1'b0}, // R8 bounce dwell
        '{5'b00010, 6'd7, 6'd7, 8'd0, 8'd0, 16'd1, 8'd2, 6'd7, 1'b0, 1'b0}, // R4 equal bounds
        '{5'b00010, 6'd2, 6'd5, 8'd0, 8'd0, 16'd0, 8'd2, 6'd4, 1'b1, 1'b0}  // R5 step 0
    };

    function automatic int lutv(input int i);
        return (i * 7 + 3) % 512;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    task automatic cfg_ch(input int c, input logic [4:0] fl, input int lo, input int hi,
                          input int hp, input int lp, input int step);
        logic [7:0] b;
        b = 8'h40 + 8'(c * 8);
        wr(b + 8'd0, 16'(lo));
        wr(b + 8'd1, 16'(hi));
        wr(b + 8'd2, 16'(step));
        wr(b + 8'd3, 16'(hp));
        wr(b + 8'd4, 16'(lp));
        wr(b + 8'd5, {11'd0, fl});
        wr(b + 8'd6, 16'(FIXED));
    endtask

    function automatic int aidx(input int c); return int'(lut_addr[c*6 +: 6]); endfunction
    function automatic int dval(input int c); return int'(duty[c*9 +: 9]); endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "busy", int'(busy), 0);
        check("R12", "done", int'(done), 0);
        check("R12", "lut_addr", int'(lut_addr), 0);
        check("R12", "duty", int'(duty), 0);

        // R1 load table while idle
        for (int i = 0; i < 64; i++) wr(8'(i), 16'(lutv(i)));

        for (int v = 0; v < NV; v++) begin
            wr(8'h81, 16'd1);
            cfg_ch(0, VECS[v].flags, int'(VECS[v].lo), int'(VECS[v].hi),
                   int'(VECS[v].hp), int'(VECS[v].lp), int'(VECS[v].step));
            wr(8'h80, 16'd1);
            ticks(int'(VECS[v].ticks));
            check("R6/R7/R8 vector", "index", aidx(0), int'(VECS[v].exp_idx));
            check("R3/R9 vector", "busy", int'(busy[0]), int'(VECS[v].exp_run));
            check("R9 vector", "done", int'(done[0]), int'(VECS[v].exp_done));
            check("R11/R4 vector", "duty", dval(0),
                  (VECS[v].exp_run || VECS[v].exp_done) ? lutv(int'(VECS[v].exp_idx)) : FIXED);
        end

        // R2: config write ignored while busy
        wr(8'h81, 16'd1);
        cfg_ch(0, 5'b00010, 2, 5, 0, 0, 1);
        wr(8'h80, 16'd1);
        wr(8'h41, 16'd3);
        ticks(3);
        check("R2", "index after busy config write", aidx(0), 5);

        // R1: table write ignored while busy
        wr(8'h03, 16'h1ff);
        wr(8'h81, 16'd1);
        cfg_ch(0, 5'b00010, 3, 5, 0, 0, 1);
        wr(8'h80, 16'd1);
        check("R1", "duty after busy table write", dval(0), lutv(3));

        // R1: idle table write takes effect
        wr(8'h81, 16'd1);
        wr(8'h0a, 16'h1ab);
        cfg_ch(0, 5'b00010, 10, 11, 0, 0, 1);
        wr(8'h80, 16'd1);
        check("R1", "duty after idle table write", dval(0), 16'h1ab);

        // R3: simultaneous start on two channels
        wr(8'h81, 16'd3);
        cfg_ch(0, 5'b00010, 2, 5, 0, 0, 1);
        cfg_ch(1, 5'b00011, 20, 25, 0, 0, 1);
        wr(8'h80, 16'd3);
        check("R3", "busy both", int'(busy), 3);
        check("R3", "ch0 index", aidx(0), 2);
        check("R3", "ch1 index", aidx(1), 25);
        ticks(1);
        check("R3", "ch0 index after tick", aidx(0), 3);
        check("R3", "ch1 index after tick", aidx(1), 24);
        check("R11", "ch1 duty", dval(1), lutv(24));

        // R10: stop one channel
        wr(8'h81, 16'd1);
        check("R10", "busy after stop", int'(busy), 2);
        check("R10", "done after stop", int'(done[0]), 0);
        check("R10", "duty after stop", dval(0), FIXED);

        // R9: held duty survives later table rewrite; start clears done
        wr(8'h81, 16'd2);
        cfg_ch(0, 5'b00000, 2, 3, 0, 0, 1);
        wr(8'h80, 16'd1);
        ticks(2);
        check("R9", "done set", int'(done[0]), 1);
        wr(8'h03, 16'h055);
        check("R9", "held duty", dval(0), lutv(3));
        wr(8'h03, 16'(lutv(3)));
        wr(8'h80, 16'd1);
        check("R9", "done cleared by start", int'(done[0]), 0);
        check("R3", "busy after restart", int'(busy[0]), 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule